// File: doc/BRIEF.md
# Configuration-Space Card Information Structure Window

This block answers configuration reads that land in the card information structure (CIS) region of a PCI/CardBus configuration space. The region starts at one of two selectable dword offsets and runs to the last dword of the 64-dword space. Each read is served from one of two sources. The first is a small fixed tuple ROM. The second is a 46-dword user tuple RAM that a serial EEPROM download fills.

The source starts as the ROM. It switches to the RAM for good, until the next reset, as soon as any download write lands in the user zone. A ready input holds off configuration accesses until the download is finished. Configuration writes may also modify the RAM lane by lane, but only while a local write-allow bit is set. Such writes change the RAM alone and never reach the EEPROM. Read data and the hit flag are registered and appear one cycle after the read is accepted.

Top module: `cis_tuple_window`

## Requirements
- R1: The window starts at dword 18 when `baseSel` is 0 and at dword 32 when it is 1, and extends through dword 63. An accepted read below the base returns zero with `cfgHit` low.
- R2: A read is accepted when `cfgRdEn` and `cfgReady` are both high. Its data and hit appear in the next cycle. In every cycle that follows a cycle with no accepted read, `cfgRdData` is zero and `cfgHit` is low.
- R3: While the source is the ROM, the index is the address minus the base. Index 0 to 3 returns 0x49430313, 0xAA042053, 0x21000155 and 0xFF000202 with `cfgHit` high. These words are the byte stream 13 03 'C' 'I' 'S' 20 04 AA 55 01 00 21 02 02 00 FF, packed with the lowest byte in bits 7:0. An index of 4 or more returns zero with `cfgHit` low.
- R4: A download write with `eeIdx` below 46 stores the full `eeWrData` dword at that RAM index and switches the source to the RAM until reset. A download write with `eeIdx` of 46 or more changes neither the RAM nor the source.
- R5: While the source is the RAM, every read inside the window returns the RAM entry at the address minus the base, with `cfgHit` high. With base 32, indices 0 to 31 are reachable.
- R6: A configuration write stores data when `cfgWrEn`, `cfgReady` and `cfgWrAllow` are high and the address is inside the window. It stores into the RAM entry at the address minus the base, whatever the current source. Bit k of `cfgByteEn` updates bits 8k+7:8k only.
- R7: A configuration write leaves the RAM unchanged when `cfgWrAllow` is low, when `cfgReady` is low, or when the address is outside the window.
- R8: A read issued while `cfgReady` is low is ignored, so the next cycle shows zero data and `cfgHit` low.
- R9: A read and a write to the same dword in the same cycle return the contents as they were before that write.
- R10: When a valid download write and a configuration write fall in the same cycle, only the download write takes effect.
- R11: After reset `cfgHit` is low, `cfgRdData` is zero, the source is the ROM and every RAM entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseSel | input | 1 | Window base select: 0 gives dword 18, 1 gives dword 32 |
| cfgReady | input | 1 | Configuration accesses accepted while high |
| cfgWrAllow | input | 1 | Local enable for configuration writes into the RAM |
| cfgRdEn | input | 1 | Configuration read request |
| cfgWrEn | input | 1 | Configuration write request |
| cfgAddr | input | 6 | Configuration dword address |
| cfgByteEn | input | 4 | Write byte-lane enables |
| cfgWrData | input | 32 | Configuration write data |
| eeWrEn | input | 1 | Download write strobe |
| eeIdx | input | 6 | Download RAM index |
| eeWrData | input | 32 | Download write data |
| cfgRdData | output | 32 | Registered read data |
| cfgHit | output | 1 | Registered window hit for the last accepted read |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a configuration read and a configuration write target the same dword, and the read must return the contents from before the write. In the second, a download write and a configuration write arrive together, and the download must win. The bench provokes both with single-cycle stimuli at chosen indices. It then reads the entries back through the RAM source and judges them against a behavioural model that applies reads before writes and gives download writes priority.

// File: rtl/cisw_pkg.sv
package cisw_pkg;
  localparam int CISW_ADDR_W = 6;
  localparam int CISW_DATA_W = 32;
  localparam int CISW_LANES  = CISW_DATA_W / 8;
  localparam int ROM_DWORDS  = 4;

  typedef struct packed {
    logic                   ramWr;
    logic [CISW_ADDR_W-1:0] wrIdx;
    logic [CISW_LANES-1:0]  wrLanes;
    logic [CISW_DATA_W-1:0] wrData;
    logic                   rdValid;
    logic                   rdFromRam;
    logic [CISW_ADDR_W-1:0] rdIdx;
  } ctrlStrobes_t;

  // fixed tuple stream, lowest byte of each dword in bits 7:0
  function automatic logic [CISW_DATA_W-1:0] romWord(input logic [CISW_ADDR_W-1:0] i);
    case (i)
      6'd0:    romWord = 32'h4943_0313;
      6'd1:    romWord = 32'hAA04_2053;
      6'd2:    romWord = 32'h2100_0155;
      6'd3:    romWord = 32'hFF00_0202;
      default: romWord = '0;
    endcase
  endfunction
endpackage

// File: rtl/cisw_ctrl.sv
module cisw_ctrl
  import cisw_pkg::*;
#(
  parameter int RAM_DEPTH = 46,
  parameter int BASE_LO   = 18,
  parameter int BASE_HI   = 32,
  parameter int LAST_DW   = 63
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   baseSel,
  input  logic                   cfgReady,
  input  logic                   cfgWrAllow,
  input  logic                   cfgRdEn,
  input  logic                   cfgWrEn,
  input  logic [CISW_ADDR_W-1:0] cfgAddr,
  input  logic [CISW_LANES-1:0]  cfgByteEn,
  input  logic [CISW_DATA_W-1:0] cfgWrData,
  input  logic                   eeWrEn,
  input  logic [CISW_ADDR_W-1:0] eeIdx,
  input  logic [CISW_DATA_W-1:0] eeWrData,
  output ctrlStrobes_t           strobes,
  output logic                   cisSelQ
);
  localparam int EW = CISW_ADDR_W + 1;
  localparam logic [EW-1:0] DEPTH_E = EW'(RAM_DEPTH);
  localparam logic [EW-1:0] LAST_E  = EW'(LAST_DW);
  localparam logic [EW-1:0] ROM_E   = EW'(ROM_DWORDS);
  localparam logic [CISW_ADDR_W-1:0] BLO = CISW_ADDR_W'(BASE_LO);
  localparam logic [CISW_ADDR_W-1:0] BHI = CISW_ADDR_W'(BASE_HI);

  logic [CISW_ADDR_W-1:0] base;
  logic [CISW_ADDR_W-1:0] idx;
  logic inWin, eeHit, cfgWrOk;

  always_comb begin
    base    = baseSel ? BHI : BLO;
    inWin   = (cfgAddr >= base) && ({1'b0, cfgAddr} <= LAST_E);
    idx     = cfgAddr - base;
    eeHit   = eeWrEn && ({1'b0, eeIdx} < DEPTH_E);
    cfgWrOk = cfgWrEn && cfgReady && cfgWrAllow && inWin;

    strobes           = '0;
    strobes.rdFromRam = cisSelQ;
    strobes.rdIdx     = idx;
    strobes.rdValid   = cfgRdEn && cfgReady && inWin &&
                        (cisSelQ || ({1'b0, idx} < ROM_E));
    if (eeHit) begin
      strobes.ramWr   = 1'b1;
      strobes.wrIdx   = eeIdx;
      strobes.wrLanes = '1;
      strobes.wrData  = eeWrData;
    end else if (cfgWrOk) begin
      strobes.ramWr   = 1'b1;
      strobes.wrIdx   = idx;
      strobes.wrLanes = cfgByteEn;
      strobes.wrData  = cfgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      cisSelQ <= 1'b0;
    else if (eeHit) cisSelQ <= 1'b1;
  end
endmodule

// File: rtl/cisw_datapath.sv
module cisw_datapath
  import cisw_pkg::*;
#(
  parameter int RAM_DEPTH = 46
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  output logic [CISW_DATA_W-1:0] rdData,
  output logic                   rdHit
);
  logic [CISW_DATA_W-1:0] mem [RAM_DEPTH];
  logic [CISW_DATA_W-1:0] srcWord;

  always_comb begin
    srcWord = strobes.rdFromRam ? mem[strobes.rdIdx] : romWord(strobes.rdIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      rdHit  <= 1'b0;
    end else begin
      rdData <= strobes.rdValid ? srcWord : '0;
      rdHit  <= strobes.rdValid;
    end
  end

  for (genvar e = 0; e < RAM_DEPTH; e++) begin : gEntry
    for (genvar l = 0; l < CISW_LANES; l++) begin : gLane
      always_ff @(posedge clk) begin
        if (!rstN)
          mem[e][8*l +: 8] <= '0;
        else if (strobes.ramWr && strobes.wrLanes[l] &&
                 strobes.wrIdx == CISW_ADDR_W'(e))
          mem[e][8*l +: 8] <= strobes.wrData[8*l +: 8];
      end
    end
  end
endmodule

// File: rtl/cis_tuple_window.sv
module cis_tuple_window
  import cisw_pkg::*;
#(
  parameter int RAM_DEPTH = 46,
  parameter int BASE_LO   = 18,
  parameter int BASE_HI   = 32,
  parameter int LAST_DW   = 63
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   baseSel,
  input  logic                   cfgReady,
  input  logic                   cfgWrAllow,
  input  logic                   cfgRdEn,
  input  logic                   cfgWrEn,
  input  logic [CISW_ADDR_W-1:0] cfgAddr,
  input  logic [CISW_LANES-1:0]  cfgByteEn,
  input  logic [CISW_DATA_W-1:0] cfgWrData,
  input  logic                   eeWrEn,
  input  logic [CISW_ADDR_W-1:0] eeIdx,
  input  logic [CISW_DATA_W-1:0] eeWrData,
  output logic [CISW_DATA_W-1:0] cfgRdData,
  output logic                   cfgHit
);
  ctrlStrobes_t strobes;
  logic         cisSelQ;

  cisw_ctrl #(
    .RAM_DEPTH(RAM_DEPTH), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI), .LAST_DW(LAST_DW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .cfgReady(cfgReady),
    .cfgWrAllow(cfgWrAllow), .cfgRdEn(cfgRdEn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .eeWrEn(eeWrEn), .eeIdx(eeIdx), .eeWrData(eeWrData),
    .strobes(strobes), .cisSelQ(cisSelQ)
  );

  cisw_datapath #(.RAM_DEPTH(RAM_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rdData(cfgRdData), .rdHit(cfgHit)
  );
endmodule

// File: rtl/cisw_checker.sv
module cisw_checker #(
  parameter int RAM_DEPTH = 46,
  parameter int BASE_LO   = 18,
  parameter int BASE_HI   = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        baseSel,
  input logic        cfgReady,
  input logic        cfgWrAllow,
  input logic        cfgRdEn,
  input logic [5:0]  cfgAddr,
  input logic        eeWrEn,
  input logic [5:0]  eeIdx,
  input logic [31:0] cfgRdData,
  input logic        cfgHit,
  input logic        cisSelQ,
  input logic        ramWr
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!(cfgRdEn && cfgReady)) |-> (!cfgHit && cfgRdData == '0));

  assert_not_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgRdEn && !cfgReady) |-> !cfgHit);

  assert_below_base_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgRdEn && cfgReady &&
          (int'(cfgAddr) < (baseSel ? BASE_HI : BASE_LO))) |-> !cfgHit);

  assert_sel_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(eeWrEn && int'(eeIdx) < RAM_DEPTH) |-> cisSelQ);

  assert_sel_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(cisSelQ) |-> cisSelQ);

  assert_write_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ramWr && !eeWrEn) |-> (cfgReady && cfgWrAllow));

  assert_reset_state_R11: assert property (@(posedge clk)
    $past(!rstN) |-> (!cfgHit && cfgRdData == '0 && !cisSelQ));
endmodule

bind cis_tuple_window cisw_checker #(
  .RAM_DEPTH(RAM_DEPTH), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
) chk_i (
  .clk(clk), .rstN(rstN), .baseSel(baseSel), .cfgReady(cfgReady),
  .cfgWrAllow(cfgWrAllow), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
  .eeWrEn(eeWrEn), .eeIdx(eeIdx), .cfgRdData(cfgRdData), .cfgHit(cfgHit),
  .cisSelQ(cisSelQ), .ramWr(strobes.ramWr)
);

// File: tb/cis_tuple_window_tb.sv
module cis_tuple_window_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baseSel = 1'b0, cfgReady = 1'b0, cfgWrAllow = 1'b0;
  logic cfgRdEn = 1'b0, cfgWrEn = 1'b0, eeWrEn = 1'b0;
  logic [5:0] cfgAddr = '0, eeIdx = '0;
  logic [3:0] cfgByteEn = '0;
  logic [31:0] cfgWrData = '0, eeWrData = '0;
  logic [31:0] cfgRdData;
  logic cfgHit;

  always #5 clk = ~clk;

  cis_tuple_window dut_i (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .cfgReady(cfgReady),
    .cfgWrAllow(cfgWrAllow), .cfgRdEn(cfgRdEn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .eeWrEn(eeWrEn), .eeIdx(eeIdx), .eeWrData(eeWrData),
    .cfgRdData(cfgRdData), .cfgHit(cfgHit)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0]  romBytes[$] = '{8'h13, 8'h03, 8'h43, 8'h49, 8'h53, 8'h20, 8'h04, 8'hAA,
                               8'h55, 8'h01, 8'h00, 8'h21, 8'h02, 8'h02, 8'h00, 8'hFF};
  logic [31:0] mRam[46];
  bit          mSel = 1'b0;

  function automatic logic [31:0] romRef(int i);
    if (i * 4 + 3 >= romBytes.size()) return '0;
    return {romBytes[i*4+3], romBytes[i*4+2], romBytes[i*4+1], romBytes[i*4]};
  endfunction

  task automatic check(string tag, logic [31:0] expD, bit expH);
    total++;
    if (cfgRdData !== expD || cfgHit !== expH) begin
      bad++;
      $display("FAIL %s: data=%h hit=%b expected data=%h hit=%b",
               tag, cfgRdData, cfgHit, expD, expH);
    end
  endtask

  task automatic step(string tag, bit rd, bit wr, int a, logic [3:0] be,
                      logic [31:0] d, bit ee, int ei, logic [31:0] ed);
    int base = baseSel ? 32 : 18;
    bit inWin = (a >= base) && (a <= 63);
    int idx = a - base;
    logic [31:0] expD = '0;
    bit expH = 1'b0;
    cfgRdEn = rd; cfgWrEn = wr; cfgAddr = 6'(a); cfgByteEn = be; cfgWrData = d;
    eeWrEn = ee; eeIdx = 6'(ei); eeWrData = ed;
    if (rd && cfgReady && inWin) begin
      if (mSel) begin expH = 1'b1; expD = mRam[idx]; end
      else if (idx < 4) begin expH = 1'b1; expD = romRef(idx); end
    end
    if (ee && ei < 46) begin
      mRam[ei] = ed; mSel = 1'b1;
    end else if (wr && cfgReady && cfgWrAllow && inWin) begin
      for (int k = 0; k < 4; k++)
        if (be[k]) mRam[idx][8*k +: 8] = d[8*k +: 8];
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, expD, expH);
  endtask

  task automatic rd(string tag, int a);
    step(tag, 1, 0, a, 4'h0, '0, 0, 0, '0);
  endtask
  task automatic cw(string tag, int a, logic [3:0] be, logic [31:0] d);
    step(tag, 0, 1, a, be, d, 0, 0, '0);
  endtask
  task automatic ew(string tag, int i, logic [31:0] d);
    step(tag, 0, 0, 0, 4'h0, '0, 1, i, d);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 46; i++) mRam[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R11 reset outputs", '0, 1'b0);

    // held off until download finishes
    rd("R8 read while not ready", 18);
    cw("R7 write while not ready", 20, 4'hF, 32'hDEAD_BEEF);
    cfgReady = 1'b1;

    // ROM source, base 18
    for (int a = 15; a <= 24; a++) rd("R3 rom read base18", a);
    step("R2 idle after read", 0, 0, 18, 4'h0, '0, 0, 0, '0);
    rd("R1 top of window", 63);
    baseSel = 1'b1;
    for (int a = 30; a <= 37; a++) rd("R1 rom read base32", a);
    baseSel = 1'b0;

    // writes into RAM while ROM still serves reads
    cw("R7 write with allow clear", 19, 4'hF, 32'h1111_1111);
    cfgWrAllow = 1'b1;
    cw("R6 full write", 20, 4'hF, 32'hA5A5_5A5A);
    cw("R6 lane write", 20, 4'b0101, 32'h1234_5678);
    cw("R6 lane write high", 21, 4'b1000, 32'hCC00_0000);
    cw("R7 write outside window", 10, 4'hF, 32'h7777_7777);
    rd("R6 rom still served", 20);

    // out-of-zone download ignored, then zone download switches source
    ew("R4 download beyond zone", 50, 32'hBAD0_BAD0);
    rd("R4 rom after ignored download", 18);
    ew("R4 download in zone", 5, 32'h0BAD_F00D);
    for (int a = 16; a <= 24; a++) rd("R5 ram read base18", a);
    rd("R11 ram zero after reset", 40);
    rd("R5 ram read top", 63);
    for (int i = 0; i < 46; i++) ew("R4 fill", i, 32'h5000_0000 + 32'(i * 32'h0101));
    for (int a = 18; a <= 63; a++) rd("R5 ram sweep base18", a);
    baseSel = 1'b1;
    for (int a = 28; a <= 63; a++) rd("R5 ram sweep base32", a);
    cw("R6 write base32", 33, 4'b0011, 32'hFFFF_9999);
    rd("R6 read base32", 33);
    baseSel = 1'b0;
    rd("R6 base18 alias", 51);

    // gating while RAM is source
    cfgWrAllow = 1'b0;
    cw("R7 allow clear", 30, 4'hF, 32'h0);
    rd("R7 allow clear readback", 30);
    cfgWrAllow = 1'b1;
    cfgReady = 1'b0;
    cw("R7 not ready", 30, 4'hF, 32'h0);
    rd("R8 read not ready", 30);
    cfgReady = 1'b1;
    rd("R7 not ready readback", 30);

    // same-cycle collisions
    step("R9 read and write same dword", 1, 1, 25, 4'hF, 32'hCAFE_0001, 0, 0, '0);
    rd("R9 readback", 25);
    step("R10 download vs config write", 0, 1, 26, 4'hF, 32'hCAFE_0002, 1, 9, 32'hEE00_0009);
    rd("R10 config write dropped", 26);
    rd("R10 download landed", 27);

    step("R2 final idle", 0, 0, 0, 4'h0, '0, 0, 0, '0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule